// File: doc/BRIEF.md
# Upstream Address Range Filter

This block sits on the inbound request path between a serial-link receiver and the host fabric. Every request that arrives (a memory read or a memory write with an address, a requester tag and a length) is tested against the top of the supported physical address space. The supported space is 64 GB, so an address is in range only when bits 63 down to 36 are all zero.

An in-range request is passed to the fabric unchanged. An out-of-range read is not forwarded. Instead it is answered on a separate error-completion channel with the Unsupported Request status. An out-of-range write is discarded without a completion, and a saturating counter records the discard. The two output channels share a single register stage. Arrival order is therefore kept, and the block sustains one request per cycle while nothing stalls.

A second, independent path handles host-generated outbound addresses. It forces bits 63 to 36 to zero, so nothing sent downstream can point above the limit.

Top module: `addr_range_filter`

## Requirements
- R1: A request whose address has bits 63..36 all zero appears on the forward channel in the cycle after it is accepted, with its write flag, address, tag and length unchanged. It never appears on the error channel.
- R2: An accepted read (`in_is_write`=0) whose address has any of bits 63..36 set produces one error completion and no forwarded request. The completion carries the read's tag, `err_status`=3'b001 (Unsupported Request) and `err_byte_count` equal to the read's length.
- R3: An accepted write whose address has any of bits 63..36 set produces neither a forwarded request nor an error completion.
- R4: Outputs leave in the order the requests were accepted. While both output readies are high, `in_ready` stays high, so one request per cycle is accepted.
- R5: When a pending output is not taken by its ready, that output's valid and fields stay unchanged and `in_ready` is low. No request is lost or duplicated. The forward and error valids are never high together.
- R6: `drop_count` rises by exactly one in the cycle after each discarded write.
- R7: `drop_count` saturates at 65535. Further discards leave it at 65535.
- R8: A high `drop_clear` sets `drop_count` to zero on the next edge, even when a discard happens in the same cycle.
- R9: `host_addr_out` equals `host_addr_in` with bits 63..36 forced to zero, combinationally.
- R10: After reset, `fwd_valid` and `err_valid` are low, `drop_count` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound request present |
| in_ready | output | 1 | Filter accepts the inbound request |
| in_is_write | input | 1 | 1 = memory write, 0 = memory read |
| in_addr | input | 64 | Inbound request address |
| in_tag | input | 8 | Requester tag |
| in_len | input | 12 | Request length in bytes |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_ready | input | 1 | Fabric takes the forwarded request |
| fwd_is_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 64 | Forwarded address |
| fwd_tag | output | 8 | Forwarded tag |
| fwd_len | output | 12 | Forwarded length |
| err_valid | output | 1 | Error completion present |
| err_ready | input | 1 | Error completion taken |
| err_tag | output | 8 | Tag of the rejected read |
| err_status | output | 3 | Completion status, 3'b001 = Unsupported Request |
| err_byte_count | output | 12 | Byte count of the rejected read |
| drop_clear | input | 1 | Synchronous clear of the discard counter |
| drop_count | output | 16 | Saturating count of discarded writes |
| host_addr_in | input | 64 | Outbound address from the host |
| host_addr_out | output | 64 | Outbound address limited to 36 bits |

## Verification
The filter is tested with several kinds of random traffic: in-range reads and writes, reads above the limit and writes above the limit. Out-of-range addresses set one random bit anywhere in 63..36, so a check that ignored part of that field would let such a request through. Directed addresses then probe the exact edge of the range: the last in-range address, a single bit 36 set, and only bit 63 set.

Random, independent output readies separate three behaviours: holding a stalled output, passing requests through with no bubble when nothing stalls, and preserving order across the two channels. Two directed phases cover the counter. A long run of discarded writes drives it into saturation, and a clear raised together with a discard shows which of the two wins.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [1:0] {
    ROUTE_FWD  = 2'd0,
    ROUTE_ERR  = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  localparam logic [2:0] CPL_UNSUPPORTED = 3'b001;

  // True when any bit at or above position lim_bits is set.
  function automatic logic above_limit(input logic [63:0] addr, input int lim_bits);
    logic [63:0] hi;
    hi = addr >> lim_bits;
    return |hi;
  endfunction

  // Clears every bit at or above position lim_bits.
  function automatic logic [63:0] clamp_addr(input logic [63:0] addr, input int lim_bits);
    logic [63:0] keep;
    keep = ~(64'hFFFF_FFFF_FFFF_FFFF << lim_bits);
    return addr & keep;
  endfunction

  // Counter step with saturation and clear priority.
  function automatic logic [15:0] sat_step(input logic [15:0] cur, input logic inc,
                                           input logic clr, input logic [15:0] top);
    if (clr) return '0;
    if (inc && cur != top) return cur + 16'd1;
    return cur;
  endfunction

endpackage

// File: rtl/arf_classify.sv
module arf_classify
  import arf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LIMIT_BITS = 36
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output route_e            route
);
  logic [63:0] addr_ext;
  logic        over;

  assign addr_ext = 64'(addr);
  assign over     = above_limit(addr_ext, LIMIT_BITS);

  always_comb begin
    if (!over)        route = ROUTE_FWD;
    else if (is_write) route = ROUTE_DROP;
    else              route = ROUTE_ERR;
  end
endmodule

// File: rtl/arf_drop_counter.sv
module arf_drop_counter
  import arf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [15:0] TOP = 16'((64'd1 << CNT_W) - 64'd1);

  logic [15:0] nxt;

  assign nxt = sat_step(16'(count), inc, clr, TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= CNT_W'(nxt);
  end
endmodule

// File: rtl/arf_out_mask.sv
module arf_out_mask
  import arf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LIMIT_BITS = 36
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  assign addr_out = ADDR_W'(clamp_addr(64'(addr_in), LIMIT_BITS));
endmodule

// File: rtl/addr_range_filter.sv
module addr_range_filter
  import arf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LIMIT_BITS = 36,
  parameter int TAG_W      = 8,
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [LEN_W-1:0]  in_len,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_is_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [LEN_W-1:0]  fwd_len,
  output logic              err_valid,
  input  logic              err_ready,
  output logic [TAG_W-1:0]  err_tag,
  output logic [2:0]        err_status,
  output logic [LEN_W-1:0]  err_byte_count,
  input  logic              drop_clear,
  output logic [CNT_W-1:0]  drop_count,
  input  logic [ADDR_W-1:0] host_addr_in,
  output logic [ADDR_W-1:0] host_addr_out
);
  route_e            in_route;
  logic              accept;
  logic              load_evt;
  logic              drop_evt;
  logic              take_evt;

  logic              slot_valid;
  route_e            slot_route;
  logic              slot_wr;
  logic [ADDR_W-1:0] slot_addr;
  logic [TAG_W-1:0]  slot_tag;
  logic [LEN_W-1:0]  slot_len;

  arf_classify #(.ADDR_W(ADDR_W), .LIMIT_BITS(LIMIT_BITS)) u_cls (
    .is_write (in_is_write),
    .addr     (in_addr),
    .route    (in_route)
  );

  assign take_evt = (fwd_valid && fwd_ready) || (err_valid && err_ready);
  assign in_ready = !slot_valid || take_evt;
  assign accept   = in_valid && in_ready;
  assign load_evt = accept && (in_route != ROUTE_DROP);
  assign drop_evt = accept && (in_route == ROUTE_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_route <= ROUTE_FWD;
      slot_wr    <= 1'b0;
      slot_addr  <= '0;
      slot_tag   <= '0;
      slot_len   <= '0;
    end else if (load_evt) begin
      slot_valid <= 1'b1;
      slot_route <= in_route;
      slot_wr    <= in_is_write;
      slot_addr  <= in_addr;
      slot_tag   <= in_tag;
      slot_len   <= in_len;
    end else if (take_evt) begin
      slot_valid <= 1'b0;
    end
  end

  assign fwd_valid      = slot_valid && (slot_route == ROUTE_FWD);
  assign fwd_is_write   = slot_wr;
  assign fwd_addr       = slot_addr;
  assign fwd_tag        = slot_tag;
  assign fwd_len        = slot_len;

  assign err_valid      = slot_valid && (slot_route == ROUTE_ERR);
  assign err_tag        = slot_tag;
  assign err_status     = CPL_UNSUPPORTED;
  assign err_byte_count = slot_len;

  arf_drop_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_evt),
    .clr   (drop_clear),
    .count (drop_count)
  );

  arf_out_mask #(.ADDR_W(ADDR_W), .LIMIT_BITS(LIMIT_BITS)) u_mask (
    .addr_in  (host_addr_in),
    .addr_out (host_addr_out)
  );
endmodule

// File: rtl/arf_checker.sv
module arf_checker #(
  parameter int ADDR_W     = 64,
  parameter int LIMIT_BITS = 36,
  parameter int TAG_W      = 8,
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [TAG_W-1:0]  fwd_tag,
  input logic [LEN_W-1:0]  fwd_len,
  input logic              err_valid,
  input logic              err_ready,
  input logic [TAG_W-1:0]  err_tag,
  input logic [LEN_W-1:0]  err_byte_count,
  input logic              drop_clear,
  input logic              drop_evt,
  input logic [CNT_W-1:0]  drop_count,
  input logic [ADDR_W-1:0] host_addr_out
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // R1
  fwd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_addr >> LIMIT_BITS) == '0);

  // R5
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_tag) && $stable(fwd_len)));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ready) |=> (err_valid && $stable(err_tag) && $stable(err_byte_count)));

  // R5
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_valid && !fwd_ready) || (err_valid && !err_ready)) |-> !in_ready);

  // R5
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, err_valid}));

  // R6
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !drop_clear && drop_count != CNT_TOP) |=> drop_count == $past(drop_count) + 1'b1);

  // R7
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_TOP && !drop_clear) |=> drop_count == CNT_TOP);

  // R8
  drop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_clear |=> drop_count == '0);

  // R9
  host_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr_out >> LIMIT_BITS) == '0);
endmodule

bind addr_range_filter arf_checker #(
  .ADDR_W(ADDR_W), .LIMIT_BITS(LIMIT_BITS), .TAG_W(TAG_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .fwd_valid      (fwd_valid),
  .fwd_ready      (fwd_ready),
  .fwd_addr       (fwd_addr),
  .fwd_tag        (fwd_tag),
  .fwd_len        (fwd_len),
  .err_valid      (err_valid),
  .err_ready      (err_ready),
  .err_tag        (err_tag),
  .err_byte_count (err_byte_count),
  .drop_clear     (drop_clear),
  .drop_evt       (drop_evt),
  .drop_count     (drop_count),
  .host_addr_out  (host_addr_out)
);

// File: tb/sim_addr_range_filter.sv
module sim_addr_range_filter;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_err;
    logic        wr;
    logic [63:0] addr;
    logic [7:0]  tag;
    logic [11:0] len;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_is_write = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [7:0]  in_tag = '0;
  logic [11:0] in_len = '0;
  logic        fwd_valid, fwd_is_write;
  logic        fwd_ready = 1'b0;
  logic [63:0] fwd_addr;
  logic [7:0]  fwd_tag;
  logic [11:0] fwd_len;
  logic        err_valid;
  logic        err_ready = 1'b0;
  logic [7:0]  err_tag;
  logic [2:0]  err_status;
  logic [11:0] err_byte_count;
  logic        drop_clear = 1'b0;
  logic [15:0] drop_count;
  logic [63:0] host_addr_in = '0;
  logic [63:0] host_addr_out;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [15:0] exp_cnt = '0;
  logic        clr_seen = 1'b0;
  logic        fhold = 1'b0, ehold = 1'b0;
  exp_t        held;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_range_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_write(in_is_write),
    .in_addr(in_addr), .in_tag(in_tag), .in_len(in_len),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_is_write(fwd_is_write),
    .fwd_addr(fwd_addr), .fwd_tag(fwd_tag), .fwd_len(fwd_len),
    .err_valid(err_valid), .err_ready(err_ready), .err_tag(err_tag),
    .err_status(err_status), .err_byte_count(err_byte_count),
    .drop_clear(drop_clear), .drop_count(drop_count),
    .host_addr_in(host_addr_in), .host_addr_out(host_addr_out)
  );

  function automatic logic out_of_range(input logic [63:0] a);
    return a[63:36] != 28'd0;
  endfunction

  function automatic logic [63:0] limited(input logic [63:0] a);
    return {28'd0, a[35:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rand_addr(input int kind);
    logic [63:0] a;
    a = {$urandom(), $urandom()};
    if (kind == 0) a = limited(a);
    else a = limited(a) | (64'd1 << (36 + ($urandom() % 28)));
    return a;
  endfunction

  // Compares outputs and updates the model; called 1 time unit after each negedge.
  task automatic evaluate();
    exp_t h;
    check("R9 host mask", host_addr_out, limited(host_addr_in));
    check("R5 one channel", {63'd0, fwd_valid & err_valid}, 64'd0);
    if (fhold) begin
      check("R5 fwd held valid", {63'd0, fwd_valid}, 64'd1);
      check("R5 fwd held addr", fwd_addr, held.addr);
      check("R5 fwd held tag", {56'd0, fwd_tag}, {56'd0, held.tag});
    end
    if (ehold) begin
      check("R5 err held valid", {63'd0, err_valid}, 64'd1);
      check("R5 err held tag", {56'd0, err_tag}, {56'd0, held.tag});
    end
    fhold = fwd_valid && !fwd_ready;
    ehold = err_valid && !err_ready;
    if (fhold || ehold) begin
      held.addr = fwd_addr; held.tag = fhold ? fwd_tag : err_tag;
      check("R5 stall ready", {63'd0, in_ready}, 64'd0);
    end
    if (fwd_valid && fwd_ready) begin
      if (q.size() == 0) check("R3 unexpected fwd", 64'd1, 64'd0);
      else begin
        h = q.pop_front();
        check("R4 order kind fwd", {63'd0, h.is_err}, 64'd0);
        check("R1 fwd addr", fwd_addr, h.addr);
        check("R1 fwd wr", {63'd0, fwd_is_write}, {63'd0, h.wr});
        check("R1 fwd tag", {56'd0, fwd_tag}, {56'd0, h.tag});
        check("R1 fwd len", {52'd0, fwd_len}, {52'd0, h.len});
      end
    end
    if (err_valid && err_ready) begin
      if (q.size() == 0) check("R3 unexpected err", 64'd1, 64'd0);
      else begin
        h = q.pop_front();
        check("R4 order kind err", {63'd0, h.is_err}, 64'd1);
        check("R2 err tag", {56'd0, err_tag}, {56'd0, h.tag});
        check("R2 err status", {61'd0, err_status}, 64'd1);
        check("R2 err byte count", {52'd0, err_byte_count}, {52'd0, h.len});
      end
    end
    if (clr_seen) check("R8 clear", {48'd0, drop_count}, {48'd0, exp_cnt});
    else if (exp_cnt == 16'hFFFF) check("R7 saturate", {48'd0, drop_count}, {48'd0, exp_cnt});
    else check("R6 drop count", {48'd0, drop_count}, {48'd0, exp_cnt});
    if (fwd_ready && err_ready && in_valid)
      check("R4 no bubble ready", {63'd0, in_ready}, 64'd1);
    clr_seen = drop_clear;
    if (drop_clear) exp_cnt = '0;
    else if (in_valid && in_ready && in_is_write && out_of_range(in_addr) && exp_cnt != 16'hFFFF)
      exp_cnt = exp_cnt + 16'd1;
    if (in_valid && in_ready && !(in_is_write && out_of_range(in_addr))) begin
      h.is_err = out_of_range(in_addr);
      h.wr = in_is_write; h.addr = in_addr; h.tag = in_tag; h.len = in_len;
      q.push_back(h);
    end
  endtask

  task automatic step(input logic v, input logic wr, input logic [63:0] a,
                      input logic fr, input logic er, input logic clr);
    @(negedge clk);
    in_valid = v; in_is_write = wr; in_addr = a;
    in_tag = 8'($urandom()); in_len = 12'($urandom());
    fwd_ready = fr; err_ready = er; drop_clear = clr;
    host_addr_in = {$urandom(), $urandom()};
    #1;
    evaluate();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10
    check("R10 fwd_valid", {63'd0, fwd_valid}, 64'd0);
    check("R10 err_valid", {63'd0, err_valid}, 64'd0);
    check("R10 drop_count", {48'd0, drop_count}, 64'd0);
    check("R10 in_ready", {63'd0, in_ready}, 64'd1);

    // Directed boundary addresses, R1 R2 R3
    step(1, 0, 64'h0000_000F_FFFF_FFFF, 1, 1, 0);
    step(1, 0, 64'h0000_0010_0000_0000, 1, 1, 0);
    step(1, 1, 64'h8000_0000_0000_0000, 1, 1, 0);
    step(1, 1, 64'h0000_000F_FFFF_FFFF, 1, 1, 0);
    step(1, 0, 64'h8000_0000_0000_0000, 1, 1, 0);
    // Stall both channels, R5
    step(1, 0, 64'h0000_0000_0000_1000, 0, 0, 0);
    step(1, 0, 64'h0000_0000_0000_2000, 0, 0, 0);
    step(1, 0, 64'h0000_0000_0000_3000, 0, 0, 0);
    step(0, 0, 64'd0, 1, 1, 0);
    step(0, 0, 64'd0, 1, 1, 0);

    // Random mix, R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 4000; i++) begin
      step(($urandom() % 5) != 0, $urandom() % 2, rand_addr($urandom() % 2),
           ($urandom() % 10) < 7, ($urandom() % 10) < 7, ($urandom() % 200) == 0);
    end
    step(0, 0, 64'd0, 1, 1, 0);
    step(0, 0, 64'd0, 1, 1, 0);

    // Saturation, R7
    for (int i = 0; i < 65600; i++) step(1, 1, rand_addr(1), 1, 1, 0);
    check("R7 at top", {48'd0, drop_count}, 64'h0000_0000_0000_FFFF);
    // Clear together with a discard, R8
    step(1, 1, rand_addr(1), 1, 1, 1);
    step(0, 0, 64'd0, 1, 1, 0);
    check("R8 after clear", {48'd0, drop_count}, 64'd0);
    check("R4 queue empty", 64'(q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule